// File: doc/BRIEF.md
# Grouped Interrupt Vector Expander

This block folds a wide field of peripheral interrupt sources, arranged as groups of eight, onto one core request line per group. Each source has a pending flag, which a one-cycle pulse on its request input sets, and a mask bit. A group's core line is high while the expander is enabled and any unmasked source in the group is pending. The core lines are presented side by side. Choosing among them is left to the processor.

When the processor acknowledges a core line, the block picks a winner inside that group at that moment. The winner is the lowest-numbered unmasked pending source. The block clears that source's flag alone and reads the source's two-word vector from a 256-word table. The vector is returned on a valid/ready output that holds its value until the consumer takes it. A software trap names a number instead. It skips the in-group selection and always lands on the group's first entry. Numbers outside the group range index the dedicated entries at the bottom of the table.

The table is a 16-bit RAM with a single port. Software reaches it through a valid/ready request port. That port reports ready low during the two cycles in which a vector fetch occupies the memory, and a read answers exactly one cycle after acceptance with no back-pressure on the response. Writes take effect only while the unlock flag is high. With the expander disabled, the table is plain RAM, the core lines stay low and no fetch is accepted.

Top module: `grpx_expander`

## Requirements
- R1: A pulse on source input k sets pending flag k. Core line g is high exactly when the block is enabled and some source in group g (inputs 8g..8g+7) is both pending and unmasked (`src_mask_i` bit high).
- R2: Core lines of different groups are independent and may be high in the same cycle.
- R3: A fetch with `fetch_trap_i`=0 and number n in 1..12 selects the lowest-index unmasked pending source i of group n-1. The vector address is 0x0D40 + 16(n-1) + 2i, and only that source's pending flag is cleared. If no source qualifies, entry i=0 is used and nothing is cleared.
- R4: A fetch with `fetch_trap_i`=1 and number n in 1..12 always uses address 0x0D40 + 16(n-1) and leaves every pending flag untouched.
- R5: A fetch whose number k is 0 or 13..31, whether trap or not, uses address 0x0D00 + 2k.
- R6: `vec_data_o` is {word at offset+1, word at offset}, where offset = `vec_addr_o` - 0x0D00. While `vec_valid_o` is high and `vec_ready_i` low, address and data hold.
- R7: A write through the RAM port changes the table only when `wr_unlock_i` is high. Otherwise the write is accepted and dropped.
- R8: With `en_i` low, all core lines are low, `fetch_ready_o` is low and the RAM port is always ready. Pending flags still latch and show once the block is enabled.
- R9: An accepted read returns `mem_rsp_valid_o` high with its data in the next cycle. `mem_req_ready_o` is low in the two cycles after a fetch handshake.
- R10: After reset, core lines, `vec_valid_o`, `mem_rsp_valid_o` and all pending flags are zero. Table contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Expander enable |
| wr_unlock_i | input | 1 | Table write unlock |
| src_req_i | input | 96 | Source request pulses, group g at bits 8g..8g+7 |
| src_mask_i | input | 96 | Source mask, 1 = enabled |
| core_line_o | output | 12 | Core request lines, bit g = group g |
| fetch_valid_i | input | 1 | Acknowledge/trap request valid |
| fetch_ready_o | output | 1 | Fetch unit idle and enabled |
| fetch_trap_i | input | 1 | 1 = software trap, 0 = acknowledge |
| fetch_num_i | input | 5 | Line or trap number |
| vec_valid_o | output | 1 | Vector result valid |
| vec_ready_i | input | 1 | Vector result consumed |
| vec_addr_o | output | 16 | Word address of vector |
| vec_data_o | output | 32 | Two-word vector |
| mem_req_valid_i | input | 1 | RAM request valid |
| mem_req_ready_o | output | 1 | RAM request ready |
| mem_we_i | input | 1 | 1 = write |
| mem_addr_i | input | 8 | RAM word address |
| mem_wdata_i | input | 16 | Write data |
| mem_rsp_valid_o | output | 1 | Read response valid |
| mem_rdata_o | output | 16 | Read data |

## Verification
The bench builds the block with its defaults: twelve groups of eight and a 256-word, 16-bit table. This brings the top corner within reach. Source 8 of group 12 lands on 0x0DFE, whose second word is the last table word, and trap 31 lands on the last dedicated entry, 0x0D3E. The default geometry lets the priority cases run on distinct groups side by side: a masked lower source skipped in favour of a higher one, a trap against a busy group, and an acknowledge of an empty group. Every vector word is checked against a table filled with an address-derived pattern.

// File: rtl/grpx_pkg.sv
package grpx_pkg;
  typedef enum logic [2:0] {
    FS_IDLE    = 3'd0,
    FS_RD_LO   = 3'd1,
    FS_RD_HI   = 3'd2,
    FS_WAIT_HI = 3'd3,
    FS_OUT     = 3'd4
  } fetch_state_e;
endpackage

// File: rtl/grpx_pend_bank.sv
module grpx_pend_bank #(
  parameter int NUM_GRP     = 12,
  parameter int SRC_PER_GRP = 8,
  localparam int NSRC  = NUM_GRP * SRC_PER_GRP,
  localparam int GRP_W = $clog2(NUM_GRP),
  localparam int SRC_W = $clog2(SRC_PER_GRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [NSRC-1:0]    src_req_i,
  input  logic [NSRC-1:0]    src_mask_i,
  input  logic               clr_valid_i,
  input  logic [GRP_W-1:0]   clr_grp_i,
  input  logic [SRC_W-1:0]   clr_src_i,
  input  logic [GRP_W-1:0]   q_grp_i,
  output logic               q_found_o,
  output logic [SRC_W-1:0]   q_idx_o,
  output logic [NUM_GRP-1:0] core_line_o
);
  logic [NUM_GRP-1:0] grp_found;
  logic [SRC_W-1:0]   grp_idx [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [SRC_PER_GRP-1:0] pend_q;
    logic [SRC_PER_GRP-1:0] act;
    logic [SRC_PER_GRP-1:0] clr_vec;
    logic [SRC_W-1:0]       win;

    assign act = pend_q & src_mask_i[g*SRC_PER_GRP +: SRC_PER_GRP];

    always_comb begin
      for (int i = 0; i < SRC_PER_GRP; i++) begin
        clr_vec[i] = clr_valid_i && (clr_grp_i == GRP_W'(g)) && (clr_src_i == SRC_W'(i));
      end
    end

    // new request in the same cycle as a clear survives
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | src_req_i[g*SRC_PER_GRP +: SRC_PER_GRP];
    end

    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
      win = '0;
      for (int i = SRC_PER_GRP - 1; i >= 0; i--) begin
        if (act[i]) win = SRC_W'(i);
      end
    end

    assign grp_found[g]   = |act;
    assign grp_idx[g]     = win;
    assign core_line_o[g] = en_i && grp_found[g];
  end

  always_comb begin
    q_found_o = 1'b0;
    q_idx_o   = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (q_grp_i == GRP_W'(g)) begin
        q_found_o = grp_found[g];
        q_idx_o   = grp_idx[g];
      end
    end
  end
endmodule

// File: rtl/grpx_vec_ram.sv
module grpx_vec_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/grpx_vec_fetch.sv
module grpx_vec_fetch
  import grpx_pkg::*;
#(
  parameter int          NUM_GRP     = 12,
  parameter int          SRC_PER_GRP = 8,
  parameter int          DATA_W      = 16,
  parameter int          TBL_DEPTH   = 256,
  parameter int          NUM_W       = 5,
  parameter logic [15:0] TABLE_BASE  = 16'h0D00,
  parameter int          GRP_OFFSET  = 64,
  localparam int GRP_W      = $clog2(NUM_GRP),
  localparam int SRC_W      = $clog2(SRC_PER_GRP),
  localparam int TBL_AW     = $clog2(TBL_DEPTH),
  localparam int GRP_STRIDE = 2 * SRC_PER_GRP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                fetch_valid_i,
  output logic                fetch_ready_o,
  input  logic                fetch_trap_i,
  input  logic [NUM_W-1:0]    fetch_num_i,
  output logic [GRP_W-1:0]    q_grp_o,
  input  logic                q_found_i,
  input  logic [SRC_W-1:0]    q_idx_i,
  output logic                clr_valid_o,
  output logic [GRP_W-1:0]    clr_grp_o,
  output logic [SRC_W-1:0]    clr_src_o,
  output logic                mem_busy_o,
  output logic [TBL_AW-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                vec_valid_o,
  input  logic                vec_ready_i,
  output logic [15:0]         vec_addr_o,
  output logic [2*DATA_W-1:0] vec_data_o
);
  fetch_state_e      state_q;
  logic [TBL_AW-1:0] off_q;
  logic [TBL_AW-1:0] off_next;
  logic [2*DATA_W-1:0] data_q;
  logic              hs;
  logic              in_grp;
  int                num_int;
  int                src_sel;
  int                off_int;

  assign fetch_ready_o = en_i && (state_q == FS_IDLE);
  assign hs            = fetch_valid_i && fetch_ready_o;

  always_comb begin
    num_int = int'(fetch_num_i);
    in_grp  = (num_int >= 1) && (num_int <= NUM_GRP);
    q_grp_o = in_grp ? GRP_W'(num_int - 1) : '0;
    src_sel = (in_grp && !fetch_trap_i && q_found_i) ? int'(q_idx_i) : 0;
    if (in_grp) off_int = GRP_OFFSET + (num_int - 1) * GRP_STRIDE + 2 * src_sel;
    else        off_int = 2 * num_int;
    off_next = TBL_AW'(off_int);
  end

  assign clr_valid_o = hs && in_grp && !fetch_trap_i && q_found_i;
  assign clr_grp_o   = q_grp_o;
  assign clr_src_o   = q_idx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      off_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (hs) begin
          off_q   <= off_next;
          state_q <= FS_RD_LO;
        end
        FS_RD_LO: state_q <= FS_RD_HI;
        FS_RD_HI: begin
          data_q[DATA_W-1:0] <= mem_rdata_i;
          state_q <= FS_WAIT_HI;
        end
        FS_WAIT_HI: begin
          data_q[2*DATA_W-1:DATA_W] <= mem_rdata_i;
          state_q <= FS_OUT;
        end
        FS_OUT: if (vec_ready_i) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_busy_o  = (state_q == FS_RD_LO) || (state_q == FS_RD_HI);
  assign mem_addr_o  = (state_q == FS_RD_HI) ? off_q + TBL_AW'(1) : off_q;
  assign vec_valid_o = (state_q == FS_OUT);
  assign vec_addr_o  = TABLE_BASE + 16'(off_q);
  assign vec_data_o  = data_q;
endmodule

// File: rtl/grpx_expander.sv
module grpx_expander #(
  parameter int          NUM_GRP     = 12,
  parameter int          SRC_PER_GRP = 8,
  parameter int          DATA_W      = 16,
  parameter int          TBL_DEPTH   = 256,
  parameter int          NUM_W       = 5,
  parameter logic [15:0] TABLE_BASE  = 16'h0D00,
  parameter int          GRP_OFFSET  = 64,
  localparam int NSRC   = NUM_GRP * SRC_PER_GRP,
  localparam int GRP_W  = $clog2(NUM_GRP),
  localparam int SRC_W  = $clog2(SRC_PER_GRP),
  localparam int TBL_AW = $clog2(TBL_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                wr_unlock_i,
  input  logic [NSRC-1:0]     src_req_i,
  input  logic [NSRC-1:0]     src_mask_i,
  output logic [NUM_GRP-1:0]  core_line_o,
  input  logic                fetch_valid_i,
  output logic                fetch_ready_o,
  input  logic                fetch_trap_i,
  input  logic [NUM_W-1:0]    fetch_num_i,
  output logic                vec_valid_o,
  input  logic                vec_ready_i,
  output logic [15:0]         vec_addr_o,
  output logic [2*DATA_W-1:0] vec_data_o,
  input  logic                mem_req_valid_i,
  output logic                mem_req_ready_o,
  input  logic                mem_we_i,
  input  logic [TBL_AW-1:0]   mem_addr_i,
  input  logic [DATA_W-1:0]   mem_wdata_i,
  output logic                mem_rsp_valid_o,
  output logic [DATA_W-1:0]   mem_rdata_o
);
  logic [GRP_W-1:0]  q_grp;
  logic              q_found;
  logic [SRC_W-1:0]  q_idx;
  logic              fetch_clr_valid;
  logic [GRP_W-1:0]  clr_grp;
  logic [SRC_W-1:0]  clr_src;
  logic              fetch_mem_busy;
  logic [TBL_AW-1:0] fetch_addr;
  logic              ram_accept;
  logic              ram_we;
  logic              ram_re;
  logic [TBL_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_rdata;
  logic              rsp_q;

  grpx_pend_bank #(.NUM_GRP(NUM_GRP), .SRC_PER_GRP(SRC_PER_GRP)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .src_req_i  (src_req_i),
    .src_mask_i (src_mask_i),
    .clr_valid_i(fetch_clr_valid),
    .clr_grp_i  (clr_grp),
    .clr_src_i  (clr_src),
    .q_grp_i    (q_grp),
    .q_found_o  (q_found),
    .q_idx_o    (q_idx),
    .core_line_o(core_line_o)
  );

  grpx_vec_fetch #(
    .NUM_GRP(NUM_GRP), .SRC_PER_GRP(SRC_PER_GRP), .DATA_W(DATA_W),
    .TBL_DEPTH(TBL_DEPTH), .NUM_W(NUM_W), .TABLE_BASE(TABLE_BASE),
    .GRP_OFFSET(GRP_OFFSET)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .fetch_valid_i(fetch_valid_i),
    .fetch_ready_o(fetch_ready_o),
    .fetch_trap_i (fetch_trap_i),
    .fetch_num_i  (fetch_num_i),
    .q_grp_o      (q_grp),
    .q_found_i    (q_found),
    .q_idx_i      (q_idx),
    .clr_valid_o  (fetch_clr_valid),
    .clr_grp_o    (clr_grp),
    .clr_src_o    (clr_src),
    .mem_busy_o   (fetch_mem_busy),
    .mem_addr_o   (fetch_addr),
    .mem_rdata_i  (ram_rdata),
    .vec_valid_o  (vec_valid_o),
    .vec_ready_i  (vec_ready_i),
    .vec_addr_o   (vec_addr_o),
    .vec_data_o   (vec_data_o)
  );

  // the fetch unit owns the single memory port while it reads
  assign mem_req_ready_o = !fetch_mem_busy;
  assign ram_accept      = mem_req_valid_i && mem_req_ready_o;
  assign ram_we          = ram_accept && mem_we_i && wr_unlock_i;
  assign ram_re          = fetch_mem_busy || (ram_accept && !mem_we_i);
  assign ram_addr        = fetch_mem_busy ? fetch_addr : mem_addr_i;

  grpx_vec_ram #(.DEPTH(TBL_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .we_i   (ram_we),
    .re_i   (ram_re),
    .addr_i (ram_addr),
    .wdata_i(mem_wdata_i),
    .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= ram_accept && !mem_we_i;
  end

  assign mem_rsp_valid_o = rsp_q;
  assign mem_rdata_o     = ram_rdata;
endmodule

// File: rtl/grpx_expander_chk.sv
module grpx_expander_chk #(
  parameter int          NUM_GRP   = 12,
  parameter int          DATA_W    = 16,
  parameter int          TBL_DEPTH = 256,
  parameter logic [15:0] TABLE_BASE = 16'h0D00
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en_i,
  input logic [NUM_GRP-1:0]  core_line_o,
  input logic                fetch_valid_i,
  input logic                fetch_ready_o,
  input logic                fetch_trap_i,
  input logic                vec_valid_o,
  input logic                vec_ready_i,
  input logic [15:0]         vec_addr_o,
  input logic [2*DATA_W-1:0] vec_data_o,
  input logic                mem_req_valid_i,
  input logic                mem_req_ready_o,
  input logic                mem_we_i,
  input logic                mem_rsp_valid_o,
  input logic                fetch_mem_busy,
  input logic                fetch_clr_valid
);
  AST_LINES_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> core_line_o == '0); // R8
  AST_NO_FETCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fetch_ready_o); // R8
  AST_RAM_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_mem_busy |-> !mem_req_ready_o); // R9
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid_o |-> $past(mem_req_valid_i && mem_req_ready_o && !mem_we_i)); // R9
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_addr_o) && $stable(vec_data_o)); // R6
  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> vec_addr_o >= TABLE_BASE && vec_addr_o < TABLE_BASE + 16'(TBL_DEPTH)
                    && !vec_addr_o[0]); // R3
  AST_CLR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_clr_valid |-> fetch_valid_i && fetch_ready_o && !fetch_trap_i); // R4
endmodule

bind grpx_expander grpx_expander_chk #(
  .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .TBL_DEPTH(TBL_DEPTH), .TABLE_BASE(TABLE_BASE)
) u_chk (.*);

// File: tb/grpx_expander_test.sv
module grpx_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        wr_unlock_i = 1'b0;
  logic [95:0] src_req_i = '0;
  logic [95:0] src_mask_i = '1;
  logic [11:0] core_line_o;
  logic        fetch_valid_i = 1'b0;
  logic        fetch_ready_o;
  logic        fetch_trap_i = 1'b0;
  logic [4:0]  fetch_num_i = '0;
  logic        vec_valid_o;
  logic        vec_ready_i = 1'b0;
  logic [15:0] vec_addr_o;
  logic [31:0] vec_data_o;
  logic        mem_req_valid_i = 1'b0;
  logic        mem_req_ready_o;
  logic        mem_we_i = 1'b0;
  logic [7:0]  mem_addr_i = '0;
  logic [15:0] mem_wdata_i = '0;
  logic        mem_rsp_valid_o;
  logic [15:0] mem_rdata_o;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  grpx_expander uut (.*);

  // {we, unlock, addr, wdata, expected read data}
  localparam logic [41:0] RAM_VEC [8] = '{
    {1'b1, 1'b1, 8'h10, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 8'h10, 16'h0000, 16'h1234},
    {1'b1, 1'b0, 8'h10, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 8'h10, 16'h0000, 16'h1234},
    {1'b1, 1'b1, 8'hFF, 16'hBEEF, 16'h0000},
    {1'b0, 1'b1, 8'hFF, 16'h0000, 16'hBEEF},
    {1'b1, 1'b1, 8'h00, 16'h0001, 16'h0000},
    {1'b0, 1'b0, 8'h00, 16'h0000, 16'h0001}
  };

  function automatic logic [15:0] pat(input int i);
    return 16'hC000 | 16'(i);
  endfunction

  function automatic logic [31:0] vexp(input logic [15:0] a);
    int o = int'(a) - 'h0D00;
    return {pat(o + 1), pat(o)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ram_op(input logic we, input logic unl, input logic [7:0] a,
                        input logic [15:0] d, output logic rv, output logic [15:0] rd);
    @(negedge clk);
    while (!mem_req_ready_o) @(negedge clk);
    mem_req_valid_i = 1'b1; mem_we_i = we; wr_unlock_i = unl;
    mem_addr_i = a; mem_wdata_i = d;
    @(negedge clk);
    rv = mem_rsp_valid_o; rd = mem_rdata_o;
    mem_req_valid_i = 1'b0; mem_we_i = 1'b0; wr_unlock_i = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_req_i[idx] = 1'b1;
    @(negedge clk);
    src_req_i[idx] = 1'b0;
  endtask

  task automatic fetch(input logic trap, input int num, input int hold,
                       output logic [15:0] a, output logic [31:0] d, output logic busy_rdy);
    @(negedge clk);
    while (!fetch_ready_o) @(negedge clk);
    fetch_valid_i = 1'b1; fetch_trap_i = trap; fetch_num_i = 5'(num);
    @(negedge clk);
    fetch_valid_i = 1'b0; fetch_trap_i = 1'b0;
    busy_rdy = mem_req_ready_o;
    for (int t = 0; t < 20 && !vec_valid_o; t++) @(negedge clk);
    a = vec_addr_o; d = vec_data_o;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R6 hold valid", {31'd0, vec_valid_o}, 32'd1);
      check("R6 hold addr", {16'd0, vec_addr_o}, {16'd0, a});
      check("R6 hold data", vec_data_o, d);
    end
    vec_ready_i = 1'b1;
    @(negedge clk);
    vec_ready_i = 1'b0;
  endtask

  task automatic fetch_chk(input string req, input logic trap, input int num,
                           input logic [15:0] exp_a);
    logic [15:0] a; logic [31:0] d; logic br;
    fetch(trap, num, 0, a, d, br);
    check({req, " addr"}, {16'd0, a}, {16'd0, exp_a});
    check("R6 data", d, vexp(exp_a));
    check("R9 ram blocked during fetch", {31'd0, br}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1..R10 actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic rv; logic [15:0] rd; logic [15:0] a; logic [31:0] d; logic br;
    repeat (3) @(negedge clk);
    check("R10 lines", {20'd0, core_line_o}, 32'd0);
    check("R10 vec_valid", {31'd0, vec_valid_o}, 32'd0);
    check("R10 rsp_valid", {31'd0, mem_rsp_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 fetch not ready when off", {31'd0, fetch_ready_o}, 32'd0);
    check("R8 ram ready when off", {31'd0, mem_req_ready_o}, 32'd1);

    // RAM mode table walk: R7 protection, R9 response timing
    for (int i = 0; i < 8; i++) begin
      ram_op(RAM_VEC[i][41], RAM_VEC[i][40], RAM_VEC[i][39:32], RAM_VEC[i][31:16], rv, rd);
      if (!RAM_VEC[i][41]) begin
        check("R9 rsp valid", {31'd0, rv}, 32'd1);
        check("R7 read data", {16'd0, rd}, {16'd0, RAM_VEC[i][15:0]});
      end else begin
        check("R9 no rsp on write", {31'd0, rv}, 32'd0);
      end
    end

    for (int i = 0; i < 256; i++) ram_op(1'b1, 1'b1, 8'(i), pat(i), rv, rd);

    // R8/R1: pending latches while disabled, line shows once enabled
    pulse(0);
    @(negedge clk);
    check("R8 line low while off", {20'd0, core_line_o}, 32'd0);
    en_i = 1'b1;
    @(negedge clk);
    check("R1 latched line", {20'd0, core_line_o}, 32'h001);
    fetch_chk("R3 g1 s1", 1'b0, 1, 16'h0D40);
    check("R3 line cleared", {20'd0, core_line_o}, 32'd0);

    // R2: groups 3 and 7 together
    @(negedge clk);
    src_req_i[16] = 1'b1; src_req_i[21] = 1'b1; src_req_i[55] = 1'b1;
    @(negedge clk);
    src_req_i = '0;
    check("R2 two lines", {20'd0, core_line_o}, 32'h044);
    fetch_chk("R3 g3 lowest", 1'b0, 3, 16'h0D60);
    check("R3 line stays", {20'd0, core_line_o}, 32'h044);
    fetch_chk("R4 trap 3", 1'b1, 3, 16'h0D60);
    check("R4 no clear", {20'd0, core_line_o}, 32'h044);
    fetch_chk("R3 g3 next", 1'b0, 3, 16'h0D6A);
    check("R3 g3 done", {20'd0, core_line_o}, 32'h040);
    fetch_chk("R3 g7 s8", 1'b0, 7, 16'h0DAE);
    check("R3 all clear", {20'd0, core_line_o}, 32'd0);

    // R1/R3 masking in group 5
    src_mask_i[33] = 1'b0;
    pulse(33);
    @(negedge clk);
    check("R1 masked no line", {20'd0, core_line_o}, 32'd0);
    pulse(34);
    check("R1 unmasked line", {20'd0, core_line_o}, 32'h010);
    fetch_chk("R3 masked skipped", 1'b0, 5, 16'h0D84);
    check("R1 masked pending hidden", {20'd0, core_line_o}, 32'd0);
    src_mask_i[33] = 1'b1;
    @(negedge clk);
    check("R1 unmask shows", {20'd0, core_line_o}, 32'h010);
    fetch_chk("R3 g5 s2", 1'b0, 5, 16'h0D82);

    pulse(95);
    fetch_chk("R3 g12 s8", 1'b0, 12, 16'h0DFE);
    fetch_chk("R3 empty group", 1'b0, 2, 16'h0D50);
    fetch_chk("R5 trap 0", 1'b1, 0, 16'h0D00);
    fetch_chk("R5 ack 14", 1'b0, 14, 16'h0D1C);
    fetch_chk("R5 trap 31", 1'b1, 31, 16'h0D3E);

    // R6 back-pressure
    fetch(1'b0, 13, 3, a, d, br);
    check("R6 bp addr", {16'd0, a}, 32'h0D1A);
    check("R6 bp data", d, vexp(16'h0D1A));
    @(negedge clk);
    check("R6 released", {31'd0, vec_valid_o}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule